// File: doc/BRIEF.md
# Lockable SMI Enable Register

This unit holds two pieces of power-management state. One is a 16-bit control word in configuration space, and one of its bits is a one-shot lock. The other is a 32-bit SMI enable register in I/O space. Every write to the enable register passes through a per-bit write mask. After reset both masks are fully open. Once firmware sets the lock, the global SMI enable bit in the I/O register is frozen. The lock bit also becomes impossible to clear, and both stay that way until the next reset. The APMC enable bit is left writable on purpose.

The configuration port takes one write per cycle. Each write carries a byte address (the low two bits select nothing, since access is by dword), four byte enables and 32 data bits. Reads are combinational from the same address. The I/O port writes or reads the whole enable register. Bus decoding, SMI generation and status bits belong to the surrounding logic.

Top module: `smi_lock_regs`

## Requirements
- R1: After reset the enable register reads 0x0000_0020 (bit 5, APMC enable, set because SMM support is present), the control word reads 0x0000 and the lock is clear.
- R2: While the lock is clear, an I/O write replaces all 32 bits of the enable register. The new value is visible on the next cycle. With no write, the register holds its value.
- R3: The control word sits in byte lanes 0 and 1 of the dword at config address 0xA0. A config write updates only the lanes whose byte enable is set. A write to any other dword leaves the word unchanged. A config read of dword 0xA0 returns {16'h0000, word}, and a read of any other address returns 0.
- R4: While the lock is set, an I/O write leaves bit 0 (global SMI enable) of the enable register unchanged and stores all other bits.
- R5: The lock is bit 4 of the control word. Once it reads 1, config writes cannot clear it, while the other 15 bits of the word stay writable.
- R6: Bit 5 (APMC enable) of the enable register remains writable whether or not the lock is set.
- R7: The lock is re-evaluated after any config write whose range touches the 8 bytes at 0xA0..0xA7, and it takes effect from the next cycle. An I/O write in the same cycle as the locking config write still uses the open mask.
- R8: Reset clears the lock and reopens both write masks.
- R9: Reads of both registers return the stored values in every lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_addr | input | 8 | Config byte address (dword granular) |
| cfg_be | input | 4 | Config byte enables |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for cfg_addr |
| io_wr | input | 1 | Enable register write strobe |
| io_wdata | input | 32 | Enable register write data |
| io_rdata | output | 32 | Enable register contents |

## Verification
The properties assume that a write strobe lasts exactly one cycle per transfer. They also assume the write data is fully defined whenever a strobe is high, because the open-mask property compares every stored bit with the previous cycle's data. The bench changes inputs only on the falling edge. It raises each strobe for a single cycle with fully specified data, and it drops the strobes before it samples the outputs.

// File: rtl/smi_lock_pkg.sv
package smi_lock_pkg;
  // Configuration bus geometry (fixed by the config space fabric)
  localparam int CFG_AW   = 8;
  localparam int CFG_DW   = 32;
  localparam int CFG_BEW  = CFG_DW / 8;

  typedef struct packed {
    logic               wr;
    logic [CFG_AW-1:0]  addr;
    logic [CFG_BEW-1:0] be;
    logic [CFG_DW-1:0]  data;
  } cfg_req_t;
endpackage

// File: rtl/cfg_window_hit.sv
module cfg_window_hit
  import smi_lock_pkg::*;
#(
  parameter int WIN_LO    = 'hA0,
  parameter int WIN_BYTES = 8
) (
  input  cfg_req_t req,
  output logic     hit
);
  localparam int WIN_HI = WIN_LO + WIN_BYTES;

  logic [CFG_AW:0] base;
  logic            in_range;

  // Any enabled byte of the dword lies in [base, base+3]
  assign base     = {1'b0, req.addr[CFG_AW-1:2], 2'b00};
  assign in_range = (int'(base) + CFG_BEW > WIN_LO) && (int'(base) < WIN_HI);
  assign hit      = req.wr && (|req.be) && in_range;
endmodule

// File: rtl/pmctl_word.sv
module pmctl_word
  import smi_lock_pkg::*;
#(
  parameter int CTL_OFF  = 'hA0,
  parameter int CTL_W    = 16,
  parameter int LOCK_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_req_t         req,
  input  logic             reval,
  output logic [CTL_W-1:0] ctl_q,
  output logic             locked_q
);
  localparam int CTL_BYTES = CTL_W / 8;
  localparam int LANE0     = CTL_OFF % CFG_BEW;
  localparam logic [CTL_W-1:0] LOCK_ONEHOT = CTL_W'(1) << LOCK_BIT;
  localparam logic [CFG_AW-3:0] CTL_DWORD  = CFG_AW'(CTL_OFF) >> 2;

  logic             word_hit;
  logic [CTL_W-1:0] wmask;
  logic [CTL_W-1:0] bit_we;
  logic [CTL_W-1:0] lane_data;
  logic [CTL_W-1:0] ctl_d;
  logic             locked_d;

  assign word_hit = req.wr && (req.addr[CFG_AW-1:2] == CTL_DWORD);
  assign wmask    = locked_q ? ~LOCK_ONEHOT : '1;

  for (genvar b = 0; b < CTL_BYTES; b++) begin : g_lane
    assign bit_we[b*8 +: 8]    = {8{word_hit && req.be[LANE0+b]}} & wmask[b*8 +: 8];
    assign lane_data[b*8 +: 8] = req.data[(LANE0+b)*8 +: 8];
  end

  always_comb begin
    ctl_d    = (ctl_q & ~bit_we) | (lane_data & bit_we);
    locked_d = reval ? ctl_d[LOCK_BIT] : locked_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (word_hit) ctl_q <= ctl_d;
      if (reval)    locked_q <= locked_d;
    end
  end

  // R5: once locked, lock state and stored lock bit never drop
  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> (locked_q && ctl_q[LOCK_BIT]));

  // R7: a window write re-evaluates the lock from the freshly stored bit
  assert_lock_reval_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reval |=> (locked_q == ctl_q[LOCK_BIT]));

  // R3: writes to other dwords leave the word alone
  assert_other_dword_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req.wr && !word_hit) |=> $stable(ctl_q));
endmodule

// File: rtl/smi_en_reg.sv
module smi_en_reg #(
  parameter int EN_W        = 32,
  parameter int GBL_BIT     = 0,
  parameter int APMC_BIT    = 5,
  parameter bit SMM_PRESENT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_wr,
  input  logic [EN_W-1:0] io_wdata,
  input  logic            lock_i,
  output logic [EN_W-1:0] en_q
);
  localparam logic [EN_W-1:0] ONE     = EN_W'(1);
  localparam logic [EN_W-1:0] GBL_OH  = ONE << GBL_BIT;
  localparam logic [EN_W-1:0] RST_VAL = SMM_PRESENT ? (ONE << APMC_BIT) : '0;

  logic [EN_W-1:0] wmask;
  logic [EN_W-1:0] en_d;

  always_comb begin
    wmask = lock_i ? ~GBL_OH : '1;
    en_d  = (en_q & ~wmask) | (io_wdata & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= RST_VAL;
    else if (io_wr) en_q <= en_d;
  end

  // R2: open mask stores the full word
  assert_open_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !lock_i) |=> (en_q == $past(io_wdata)));

  // R2: no write, no change
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(en_q));

  // R4: global enable frozen under lock
  assert_gbl_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && lock_i) |=> (en_q[GBL_BIT] == $past(en_q[GBL_BIT])));

  // R6: APMC enable always follows the write data
  assert_apmc_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |=> (en_q[APMC_BIT] == $past(io_wdata[APMC_BIT])));
endmodule

// File: rtl/smi_lock_regs.sv
module smi_lock_regs
  import smi_lock_pkg::*;
#(
  parameter int EN_W        = 32,
  parameter int GBL_BIT     = 0,
  parameter int APMC_BIT    = 5,
  parameter bit SMM_PRESENT = 1'b1,
  parameter int CTL_OFF     = 'hA0,
  parameter int CTL_W       = 16,
  parameter int LOCK_BIT    = 4,
  parameter int WIN_BYTES   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_BEW-1:0] cfg_be,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              io_wr,
  input  logic [EN_W-1:0]   io_wdata,
  output logic [EN_W-1:0]   io_rdata
);
  localparam int LANE0 = CTL_OFF % CFG_BEW;
  localparam logic [CFG_AW-3:0] CTL_DWORD = CFG_AW'(CTL_OFF) >> 2;

  cfg_req_t         req;
  logic             reval;
  logic [CTL_W-1:0] ctl_q;
  logic             locked_q;
  logic [EN_W-1:0]  en_q;
  logic             unused_addr_lsb;

  assign req = '{wr: cfg_wr, addr: cfg_addr, be: cfg_be, data: cfg_wdata};
  assign unused_addr_lsb = ^cfg_addr[1:0];

  cfg_window_hit #(.WIN_LO(CTL_OFF), .WIN_BYTES(WIN_BYTES)) u_win (
    .req (req),
    .hit (reval)
  );

  pmctl_word #(.CTL_OFF(CTL_OFF), .CTL_W(CTL_W), .LOCK_BIT(LOCK_BIT)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .reval    (reval),
    .ctl_q    (ctl_q),
    .locked_q (locked_q)
  );

  smi_en_reg #(.EN_W(EN_W), .GBL_BIT(GBL_BIT), .APMC_BIT(APMC_BIT),
               .SMM_PRESENT(SMM_PRESENT)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .lock_i   (locked_q),
    .en_q     (en_q)
  );

  // R9: reads are straight views of stored state
  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr[CFG_AW-1:2] == CTL_DWORD)
      cfg_rdata[LANE0*8 +: CTL_W] = ctl_q;
  end

  assign io_rdata = en_q;
endmodule

// File: tb/smi_lock_regs_test.sv
`timescale 1ns/1ps
module smi_lock_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [7:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        io_wr;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  smi_lock_regs uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  // Row: {req(4), is_cfg(1), addr(8), be(4), data(32), exp_io(32), exp_ctl(16)}
  localparam int NV = 14;
  localparam logic [96:0] VEC [NV] = '{
    {4'd2, 1'b0, 8'h00, 4'h0, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 16'h0000},
    {4'd2, 1'b0, 8'h00, 4'h0, 32'h0000_0001, 32'h0000_0001, 16'h0000},
    {4'd3, 1'b1, 8'hA0, 4'h2, 32'h0000_FF00, 32'h0000_0001, 16'hFF00},
    {4'd3, 1'b1, 8'hA4, 4'hF, 32'hFFFF_FFFF, 32'h0000_0001, 16'hFF00},
    {4'd3, 1'b1, 8'hA0, 4'h1, 32'h0000_00EF, 32'h0000_0001, 16'hFFEF},
    {4'd2, 1'b0, 8'h00, 4'h0, 32'h0000_0000, 32'h0000_0000, 16'hFFEF},
    {4'd2, 1'b0, 8'h00, 4'h0, 32'h0000_0001, 32'h0000_0001, 16'hFFEF},
    {4'd5, 1'b1, 8'hA0, 4'h3, 32'h0000_1234, 32'h0000_0001, 16'h1234},
    {4'd4, 1'b0, 8'h00, 4'h0, 32'h0000_0000, 32'h0000_0001, 16'h1234},
    {4'd6, 1'b0, 8'h00, 4'h0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 16'h1234},
    {4'd6, 1'b0, 8'h00, 4'h0, 32'h0000_0000, 32'h0000_0001, 16'h1234},
    {4'd5, 1'b1, 8'hA0, 4'h3, 32'h0000_ABC0, 32'h0000_0001, 16'hABD0},
    {4'd5, 1'b1, 8'hA0, 4'h1, 32'h0000_0000, 32'h0000_0001, 16'hAB10},
    {4'd9, 1'b1, 8'hA2, 4'h3, 32'h0000_0000, 32'h0000_0001, 16'h0010}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One transfer: drive at falling edge, sample at the next falling edge
  task automatic xfer(input logic c, input logic [7:0] a, input logic [3:0] be,
                      input logic [31:0] cd, input logic i, input logic [31:0] id);
    @(negedge clk);
    cfg_wr = c; cfg_addr = a; cfg_be = be; cfg_wdata = cd;
    io_wr = i; io_wdata = id;
    @(negedge clk);
    cfg_wr = 1'b0; io_wr = 1'b0; cfg_addr = 8'hA0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cfg_addr = 8'hA0;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = 8'hA0; cfg_be = '0;
    cfg_wdata = '0; io_wr = 1'b0; io_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1: reset state
    chk("R1 enable reset", io_rdata, 32'h0000_0020);
    chk("R1 control reset", cfg_rdata, 32'h0000_0000);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      logic [3:0]  rq;
      logic        isc;
      logic [7:0]  a;
      logic [3:0]  be;
      logic [31:0] d, eio;
      logic [15:0] ectl;
      {rq, isc, a, be, d, eio, ectl} = VEC[k];
      if (isc) xfer(1'b1, a, be, d, 1'b0, 32'h0);
      else     xfer(1'b0, 8'h00, 4'h0, 32'h0, 1'b1, d);
      chk($sformatf("R%0d/R9 row %0d io", rq, k), io_rdata, eio);
      chk($sformatf("R%0d/R9 row %0d cfg", rq, k), cfg_rdata, {16'h0, ectl});
    end

    // R3: other addresses read zero even while locked
    cfg_addr = 8'hA4; #1;
    chk("R3 read other dword", cfg_rdata, 32'h0);
    cfg_addr = 8'h10; #1;
    chk("R3 read far address", cfg_rdata, 32'h0);

    // R8: reset unlocks and reopens both masks
    do_reset();
    chk("R8 enable after reset", io_rdata, 32'h0000_0020);
    chk("R8 control after reset", cfg_rdata, 32'h0);
    xfer(1'b0, 8'h00, 4'h0, 32'h0, 1'b1, 32'h0000_0001);
    chk("R8 gbl writable after reset", io_rdata, 32'h0000_0001);
    xfer(1'b1, 8'hA0, 4'h1, 32'h0000_0010, 1'b0, 32'h0);
    xfer(1'b1, 8'hA0, 4'h1, 32'h0000_0000, 1'b0, 32'h0);
    chk("R5 lock set after reset cannot clear", cfg_rdata, 32'h0000_0010);
    do_reset();
    xfer(1'b1, 8'hA0, 4'h1, 32'h0000_0000, 1'b0, 32'h0);
    chk("R8 lock bit writable after reset", cfg_rdata, 32'h0);

    // R7: same-cycle I/O write uses the open mask
    xfer(1'b0, 8'h00, 4'h0, 32'h0, 1'b1, 32'h0000_0001);
    chk("R7 setup", io_rdata, 32'h0000_0001);
    xfer(1'b1, 8'hA0, 4'h1, 32'h0000_0010, 1'b1, 32'h0000_0000);
    chk("R7 same-cycle write clears gbl", io_rdata, 32'h0000_0000);
    chk("R7 lock stored", cfg_rdata, 32'h0000_0010);
    xfer(1'b0, 8'h00, 4'h0, 32'h0, 1'b1, 32'h0000_0021);
    chk("R7 R4 gbl frozen at 0 next cycle", io_rdata, 32'h0000_0020);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule